// File: doc/BRIEF.md
# Temporal Gray-Level Dither Engine

This block turns 4-bit intensity codes into one-bit on/off decisions for passive display panels, which can only switch a pixel fully on or fully off. A pixel is shown at an intermediate brightness by lighting it in only some frames. A frame counter runs through a 15-frame cycle. At a code whose on-time is L, a pixel is lit in exactly L frames of each cycle, so every channel shows 15 distinct levels.

Each pixel starts its 15-frame cycle at a different point. That starting point is a small hash of the low bits of the pixel's column and row. In colour mode, each component also gets its own fixed offset. Pixels and components next to each other therefore do not blink in step. In colour mode, red, green and blue are each dithered on their own, which gives 15 x 15 x 15 = 3375 combinations. In monochrome mode only the first channel is used.

Upstream logic supplies one pixel per cycle: its codes, its x/y position, a valid flag, and a pulse at each frame start. The decisions come out one cycle later, ready for a pin-packing stage.

Top module: `dith_engine`

## Requirements
- R1: While rst_n is low, out_valid and out_bits are 0. After reset the frame index is 0, so the first frame's pixels use frame value 0.
- R2: Code 0 never lights a pixel and code 15 always lights it, whatever the frame or position.
- R3: Code c has on-time c, except code 8, whose on-time is 7. Codes 7 and 8 therefore share one level, leaving 15 distinct on-times (0 to 7 and 9 to 15). At a fixed position, a pixel is lit in exactly that many frames out of any 15 consecutive frames.
- R4: The frame index counts 0 to 14 and wraps to 0. It advances by one on each cycle where frame_start is high. A pixel presented in the same cycle as frame_start uses the index held before that advance.
- R5: The position hash is h = (4*(x mod 4) + 7*(y mod 4)) mod 15. For channel k (0 = red, 1 = green, 2 = blue), the phase is (frame + h + 5*k) mod 15. The channel bit is 1 exactly when the phase is less than the code's on-time.
- R6: out_bits[0] carries red (or mono), out_bits[1] green, and out_bits[2] blue. With color_mode low, bit 0 is decided from code_r with channel offset 0. Bits 2:1 are 0, and code_g and code_b have no effect.
- R7: Latency is one cycle. out_valid equals pix_valid of the previous cycle, and out_bits is decided from that cycle's codes, position, mode and frame index.
- R8: out_bits is 0 whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that advances the frame index |
| pix_valid | input | 1 | Pixel inputs are valid this cycle |
| color_mode | input | 1 | 1 = three-channel colour, 0 = monochrome on channel 0 |
| code_r | input | 4 | Red (or mono) intensity code |
| code_g | input | 4 | Green intensity code |
| code_b | input | 4 | Blue intensity code |
| pix_x | input | 10 | Pixel column |
| pix_y | input | 10 | Pixel row |
| out_valid | output | 1 | out_bits is valid |
| out_bits | output | 3 | On/off decisions {blue, green, red/mono} |

## Verification
The assertions check these properties on every cycle:
- the frame index stays below 15, steps by one only on frame_start, and is otherwise stable;
- the one-cycle valid latency holds;
- the two end codes (0 and 15) give fixed outputs;
- idle or disabled channels stay dark.

Some properties cannot be seen from a single cycle: the exact on-time for each code over a full 15-frame cycle, the position and channel phase offsets, and the sharing of one level by codes 7 and 8. These show only in the bench's scenarios, where every output is compared against an independently computed phase and each code is counted across 15 frames at fixed positions.

// File: rtl/dith_pkg.sv
package dith_pkg;

  localparam int unsigned CYCLE_LEN = 15;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_CH    = 3;
  localparam int unsigned CH_STEP   = 5;
  localparam int unsigned HX_MUL    = 4;
  localparam int unsigned HY_MUL    = 7;

  typedef logic [CODE_W-1:0] code_t;

  // Reduce a small sum into the 15-frame ring.
  function automatic code_t ring15(input logic [7:0] v);
    logic [7:0] r;
    r = v % 8'd15;
    return r[3:0];
  endfunction

  // Map a code to the number of lit frames per cycle; 8 folds onto 7.
  function automatic code_t code_to_ontime(input code_t c);
    return (c == 4'd8) ? 4'd7 : c;
  endfunction

  // Spatial phase from the low coordinate bits.
  function automatic code_t pos_hash(input logic [3:0] xl, input logic [3:0] yl);
    logic [7:0] s;
    s = 8'(HX_MUL) * {4'd0, xl} + 8'(HY_MUL) * {4'd0, yl};
    return ring15(s);
  endfunction

  // Combined phase of frame, position and channel offset.
  function automatic code_t phase_of(input code_t frame, input code_t h,
                                     input code_t ofs);
    return ring15({4'd0, frame} + {4'd0, h} + {4'd0, ofs});
  endfunction

  function automatic logic lit(input code_t ph, input code_t code);
    return ph < code_to_ontime(code);
  endfunction

endpackage

// File: rtl/dith_frame_ctr.sv
module dith_frame_ctr
  import dith_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  output code_t frame_idx,
  output logic  wrap_evt
);

  code_t cnt_q;

  assign wrap_evt  = frame_start && (cnt_q == code_t'(CYCLE_LEN - 1));
  assign frame_idx = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (frame_start)
      cnt_q <= wrap_evt ? '0 : cnt_q + 4'd1;
  end

  // R4: index never leaves the 15-frame ring
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < code_t'(CYCLE_LEN));

  // R4: one step per frame pulse, wrapping after 14
  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cnt_q == (($past(cnt_q) == 4'd14) ? 4'd0 : $past(cnt_q) + 4'd1)));

  // R4: held between frame pulses
  a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cnt_q));

endmodule

// File: rtl/dith_pos_hash.sv
module dith_pos_hash
  import dith_pkg::*;
#(
  parameter int unsigned XW = 10,
  parameter int unsigned YW = 10,
  parameter int unsigned HASH_BITS = 2
) (
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  output code_t         hash
);

  logic [3:0] x_low;
  logic [3:0] y_low;

  always_comb begin
    x_low = '0;
    y_low = '0;
    x_low[HASH_BITS-1:0] = pix_x[HASH_BITS-1:0];
    y_low[HASH_BITS-1:0] = pix_y[HASH_BITS-1:0];
  end

  assign hash = pos_hash(x_low, y_low);

  // R5: hash is a phase inside the ring
  always_comb begin
    a_r5_hash_range: assert (hash < code_t'(CYCLE_LEN));
  end

endmodule

// File: rtl/dith_chan_slice.sv
module dith_chan_slice
  import dith_pkg::*;
#(
  parameter int unsigned CH_OFS = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  code_t code,
  input  code_t frame_idx,
  input  code_t hash,
  output logic  bit_q
);

  localparam code_t OFS = code_t'(CH_OFS % CYCLE_LEN);

  code_t phase;
  logic  on_now;

  assign phase  = phase_of(frame_idx, hash, OFS);
  assign on_now = take && lit(phase, code);

  always_ff @(posedge clk) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= on_now;
  end

  // R2: code 0 stays dark
  a_r2_code0_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (take && code == 4'd0) |=> !bit_q);

  // R2: code 15 always lit
  a_r2_code15_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (take && code == 4'd15) |=> bit_q);

  // R8: a channel not taken stays dark
  a_r8_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !bit_q);

endmodule

// File: rtl/dith_engine.sv
module dith_engine
  import dith_pkg::*;
#(
  parameter int unsigned XW = 10,
  parameter int unsigned YW = 10,
  parameter int unsigned HASH_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          pix_valid,
  input  logic          color_mode,
  input  logic [3:0]    code_r,
  input  logic [3:0]    code_g,
  input  logic [3:0]    code_b,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  output logic          out_valid,
  output logic [2:0]    out_bits
);

  code_t frame_idx;
  logic  wrap_evt;
  code_t hash;
  code_t codes [NUM_CH];
  logic  ch_take [NUM_CH];

  assign codes[0] = code_r;
  assign codes[1] = code_g;
  assign codes[2] = code_b;

  dith_frame_ctr u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_idx   (frame_idx),
    .wrap_evt    (wrap_evt)
  );

  dith_pos_hash #(
    .XW        (XW),
    .YW        (YW),
    .HASH_BITS (HASH_BITS)
  ) u_hash (
    .pix_x (pix_x),
    .pix_y (pix_y),
    .hash  (hash)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    if (k == 0) begin : g_base
      assign ch_take[k] = pix_valid;
    end else begin : g_color
      assign ch_take[k] = pix_valid && color_mode;
    end

    dith_chan_slice #(
      .CH_OFS (k * CH_STEP)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (ch_take[k]),
      .code      (codes[k]),
      .frame_idx (frame_idx),
      .hash      (hash),
      .bit_q     (out_bits[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= pix_valid;
  end

  // R7: one-cycle latency on the valid flag
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  // R6: monochrome leaves bits 2:1 dark
  a_r6_mono_upper_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !color_mode) |=> (out_bits[2:1] == 2'b00));

  // R8: no lit bit without valid
  a_r8_bits_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_bits == 3'b000));

endmodule

// File: tb/sim_dith_engine.sv
module sim_dith_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic       color_mode = 1'b0;
  logic [3:0] code_r = '0, code_g = '0, code_b = '0;
  logic [9:0] pix_x = '0, pix_y = '0;
  logic       out_valid;
  logic [2:0] out_bits;

  int n_cmp = 0;
  int n_bad = 0;
  int f_model = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dith_engine u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .color_mode(color_mode), .code_r(code_r), .code_g(code_g), .code_b(code_b),
    .pix_x(pix_x), .pix_y(pix_y), .out_valid(out_valid), .out_bits(out_bits)
  );

  function automatic int ontime(input int c);
    if (c == 8) return 7;
    return c;
  endfunction

  function automatic bit exp_lit(input int c, input int x, input int y,
                                 input int f, input int ch);
    int h;
    int ph;
    h  = ((x % 4) * 4 + (y % 4) * 7) % 15;
    ph = (f + h + 5 * ch) % 15;
    return ph < ontime(c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input bit fs, input bit pv, input bit cm,
                      input int r, input int g, input int b,
                      input int x, input int y, input string req,
                      output logic [2:0] got);
    logic [2:0] e;
    @(negedge clk);
    frame_start = fs; pix_valid = pv; color_mode = cm;
    code_r = 4'(r); code_g = 4'(g); code_b = 4'(b);
    pix_x = 10'(x); pix_y = 10'(y);
    e = 3'b000;
    if (pv) begin
      e[0] = exp_lit(r, x, y, f_model, 0);
      if (cm) begin
        e[1] = exp_lit(g, x, y, f_model, 1);
        e[2] = exp_lit(b, x, y, f_model, 2);
      end
    end
    @(posedge clk);
    #1;
    check(out_valid == pv, "R7 valid", int'(out_valid), int'(pv));
    check(out_bits == e, req, int'(out_bits), int'(e));
    got = out_bits;
    if (fs) f_model = (f_model + 1) % 15;
  endtask

  initial begin
    logic [2:0] got;
    int lit_cnt;
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(out_bits == 3'b000, "R1 reset bits", int'(out_bits), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: first frame uses index 0 (phase check at mid code)
    step(0, 1, 1, 6, 6, 6, 0, 0, "R1 first frame", got);
    step(0, 1, 1, 6, 6, 6, 3, 2, "R1 first frame", got);

    // R2: end codes over a whole cycle and several positions
    for (int f = 0; f < 15; f++) begin
      step(1, 1, 1, 0, 15, 0, f, 3 * f, "R2 end codes", got);
      check(got == 3'b010, "R2 0 dark 15 lit", int'(got), 2);
    end

    // R3: count lit frames per code over 15 frames at fixed positions
    for (int c = 0; c < 16; c++) begin
      lit_cnt = 0;
      for (int f = 0; f < 15; f++) begin
        step(1, 1, 0, c, 0, 0, c + 1, 2 * c, "R3 per-frame", got);
        lit_cnt += int'(got[0]);
      end
      check(lit_cnt == ontime(c), "R3 lit-frame count", lit_cnt, ontime(c));
    end

    // R4: pixels without frame pulses hold phase; pulse with pixel uses old index
    for (int i = 0; i < 6; i++) step(0, 1, 1, 7, 9, 11, 1, 1, "R4 hold", got);
    for (int i = 0; i < 20; i++) step(1, 1, 1, 7, 9, 11, 1, 1, "R4 wrap", got);

    // R5: neighbouring columns and rows, colour offsets
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 4; y++)
        step(0, 1, 1, 5, 10, 13, x, y, "R5 spatial", got);

    // R6: mono mode ignores green/blue codes
    for (int i = 0; i < 10; i++) begin
      step(i % 3 == 0, 1, 0, 15, 15, 15, i, i, "R6 mono", got);
      check(got[2:1] == 2'b00, "R6 upper dark", int'(got[2:1]), 0);
    end

    // R8: invalid cycles stay dark even with lit codes
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 1, 15, 15, 15, i, i, "R8 idle", got);
      check(got == 3'b000, "R8 idle dark", int'(got), 0);
    end

    // R5 R7: random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 8) == 0, ($urandom % 5) != 0, $urandom % 2,
           $urandom % 16, $urandom % 16, $urandom % 16,
           $urandom % 1024, $urandom % 1024, "R5 random", got);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule